// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a down-counting watchdog that firmware steers only by writing command words to a key register. A start command sets it running. From then on it counts prescaled clock ticks down from a programmed reload value. If firmware does not send a refresh command in time, the counter reaches zero. The block then pulses a reset-request output for one clock and reloads. Once running, only a reset stops the watchdog.

The prescaler code and the 12-bit reload value sit behind a write-access guard. A dedicated key value opens the guard. Any other key value closes it again, and so do the start and refresh commands. A write to either configuration register does not take effect at once. It first sets a busy flag in the status register, and the new value is applied when a fixed settling delay has passed. Access is through a simple synchronous register bus. Writes are single-cycle strobes, and read data follows the address combinationally.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the prescaler register (address 1) reads 0, the reload register (address 2) reads 0xFFF, the status register (address 3) reads 0, access is locked, the watchdog is stopped, and the reset request is low.
- R2: Writing 0x5555 to the key register (address 0) opens write access. While access is locked, writes to addresses 1 and 2 are ignored and set no busy flag.
- R3: An accepted write to address 1 sets status bit 0, and an accepted write to address 2 sets status bit 1. The bit reads 1 in the 4 cycles that follow the write edge. The new value is readable and in force from the 4th edge after the write, when the bit clears.
- R4: Writing 0xCCCC to the key register starts a stopped watchdog. It loads the counter with the reload value R and clears the divider. The reset request goes high for exactly one cycle after the edge (R+1)*D clocks past the start edge, where D is the division ratio. It then repeats every (R+1)*D clocks.
- R5: Writing 0xAAAA to the key register reloads the counter from the reload register and clears the divider. The next request then follows (R+1)*D clocks after that write edge.
- R6: The keys 0xAAAA and 0xCCCC, and any value other than 0x5555, close write access.
- R7: Prescaler codes 0 to 6 give D = 4 << code, that is 4 through 256. Codes 7 and above give D = 256.
- R8: No request occurs while the watchdog is stopped, and a refresh while stopped does not start it. Once started, key writes cannot stop it. A second start or an unrecognised key leaves the count unchanged.
- R9: A refresh written on the same edge as a timeout suppresses that request and restarts the period.
- R10: Address 0 reads as 0. Only the low 12 bits of a reload write are kept, and only the low 3 bits of a prescaler write are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| wdt_reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
Read data is combinational, so every register read is sampled in the low phase of the clock following the write edge. The busy flag is due in the cycle right after that edge, and the applied value is due four edges later. The bench steps one negative edge at a time across that window. The reset request is registered, and it is due in the cycle after edge (R+1)*D counted from the start or refresh edge. The bench counts rising edges from the command edge and compares the edge count at which it first sees the request high against that product, for every prescaler code and several reload values. A refresh is aimed at the exact timeout edge to check the suppression case.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_KEY  = 2'd0,
    A_PSC  = 2'd1,
    A_RLD  = 2'd2,
    A_STAT = 2'd3
  } wdg_addr_e;

  localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_RELOAD = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;
endpackage

// File: rtl/wdg_keyctl.sv
module wdg_keyctl
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              unlocked,
  output logic              start_p,
  output logic              reload_p
);
  // Command pulses are combinational so they act on the write edge itself
  assign start_p  = key_wr && (key_data == KEY_START);
  assign reload_p = key_wr && (key_data == KEY_RELOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (key_data == KEY_UNLOCK);
  end
endmodule

// File: rtl/wdg_cfg_shadow.sv
module wdg_cfg_shadow #(
  parameter int          W       = 12,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int          SETTLE  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         busy,
  output logic [W-1:0] value
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  pend;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pend  <= RST_VAL;
      value <= RST_VAL;
    end else if (wr) begin
      // a fresh write restarts the settling window
      cnt  <= CW'(SETTLE);
      pend <= wdata;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) value <= pend;
    end
  end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PSC_W        = 3,
  parameter int DIV_MIN_LOG2 = 2,
  parameter int DIV_STEPS    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int DW = DIV_MIN_LOG2 + DIV_STEPS - 1;

  logic [DW-1:0] div_q;
  logic [DW-1:0] thr;
  logic [DW:0]   span;
  int            sat;

  always_comb begin
    sat  = (int'(code) >= DIV_STEPS) ? DIV_STEPS - 1 : int'(code);
    span = (DW+1)'(1) << (DIV_MIN_LOG2 + sat);
    thr  = DW'(span - 1'b1);
  end

  // >= keeps a shrink of the ratio from skipping the terminal count
  assign tick = run && !clear && (div_q >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     div_q <= '0;
    else if (clear || !run || tick) div_q <= '0;
    else                            div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         req
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '1;
      req <= 1'b0;
    end else begin
      req <= tick && (cnt == '0) && !load;
      if (load)                         cnt <= load_val;
      else if (tick && cnt == '0)       cnt <= load_val;
      else if (tick)                    cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int RLD_W        = 12,
  parameter int PSC_W        = 3,
  parameter int SETTLE       = 4,
  parameter int DIV_MIN_LOG2 = 2,
  parameter int DIV_STEPS    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_reset_req
);
  logic             unlocked, start_p, reload_p;
  logic             run_q, load, tick;
  logic             psc_busy, rld_busy;
  logic [PSC_W-1:0] psc_val;
  logic [RLD_W-1:0] rld_val;

  wdg_keyctl u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (bus_wr && bus_addr == A_KEY),
    .key_data (bus_wdata),
    .unlocked (unlocked),
    .start_p  (start_p),
    .reload_p (reload_p)
  );

  wdg_cfg_shadow #(.W(PSC_W), .RST_VAL('0), .SETTLE(SETTLE)) u_psc_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr && bus_addr == A_PSC && unlocked),
    .wdata (bus_wdata[PSC_W-1:0]),
    .busy  (psc_busy),
    .value (psc_val)
  );

  wdg_cfg_shadow #(.W(RLD_W), .RST_VAL('1), .SETTLE(SETTLE)) u_rld_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr && bus_addr == A_RLD && unlocked),
    .wdata (bus_wdata[RLD_W-1:0]),
    .busy  (rld_busy),
    .value (rld_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (start_p) run_q <= 1'b1;
  end

  // a start only reloads when stopped; a refresh always reloads
  assign load = reload_p || (start_p && !run_q);

  wdg_prescaler #(.PSC_W(PSC_W), .DIV_MIN_LOG2(DIV_MIN_LOG2), .DIV_STEPS(DIV_STEPS)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .clear (load),
    .code  (psc_val),
    .tick  (tick)
  );

  wdg_downcount #(.W(RLD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (rld_val),
    .tick     (tick),
    .req      (wdt_reset_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PSC:   bus_rdata = DATA_W'(psc_val);
      A_RLD:   bus_rdata = DATA_W'(rld_val);
      A_STAT:  bus_rdata = DATA_W'({rld_busy, psc_busy});
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        wdt_reset_req,
  input logic        run_q,
  input logic        unlocked,
  input logic        psc_busy,
  input logic        rld_busy
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !wdt_reset_req); // R8
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q); // R8
  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata == 16'h5555) |=> unlocked); // R2
  AST_CMD_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && (bus_wdata == 16'hAAAA || bus_wdata == 16'hCCCC)) |=> !unlocked); // R6
  AST_PSC_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psc_busy) |-> $past(bus_wr && bus_addr == 2'd1 && unlocked)); // R2
  AST_RLD_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rld_busy) |-> $past(bus_wr && bus_addr == 2'd2 && unlocked)); // R3
endmodule

bind keyed_watchdog wdg_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .wdt_reset_req (wdt_reset_req),
  .run_q         (run_q),
  .unlocked      (unlocked),
  .psc_busy      (psc_busy),
  .rld_busy      (rld_busy)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        wdt_reset_req;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  keyed_watchdog uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_reset_req(wdt_reset_req)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output int d);
    bus_addr = a; #1; d = int'(bus_rdata);
  endtask

  task automatic rd(logic [1:0] a, output int d);
    @(negedge clk); peek(a, d);
  endtask

  // counts rising edges until the request is seen high (0 = none within lim)
  task automatic measure(int lim, output int k);
    k = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_reset_req) begin k = i; return; end
    end
  endtask

  function automatic int ratio(int code);
    return 4 << ((code > 6) ? 6 : code);
  endfunction

  task automatic setup(int code, int rl);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(code));
    wr(2'd2, 16'(rl));
    repeat (6) @(posedge clk);
  endtask

  int v, s, k;
  int rl_set[4] = '{0, 1, 2, 5};

  initial begin
    do_reset();
    // R1 reset state
    rd(2'd1, v); chk("R1 psc", v, 0);
    rd(2'd2, v); chk("R1 rld", v, 12'hFFF);
    rd(2'd3, v); chk("R1 status", v, 0);
    chk("R1 req", int'(wdt_reset_req), 0);
    // R10 key reads zero
    rd(2'd0, v); chk("R10 key read", v, 0);

    // R2 locked write ignored
    wr(2'd1, 16'h0005);
    rd(2'd3, v); chk("R2 locked no flag", v, 0);
    repeat (6) @(posedge clk);
    rd(2'd1, v); chk("R2 locked psc", v, 0);
    // R6 refresh key relocks
    wr(2'd0, 16'h5555); wr(2'd0, 16'hAAAA); wr(2'd1, 16'h0005);
    rd(2'd3, v); chk("R6 relock by refresh", v, 0);
    // R6 other key relocks
    wr(2'd0, 16'h5555); wr(2'd0, 16'h1234); wr(2'd2, 16'h0010);
    rd(2'd3, v); chk("R6 relock by other key", v, 0);
    repeat (6) @(posedge clk);
    rd(2'd2, v); chk("R6 rld unchanged", v, 12'hFFF);

    // R3 prescaler update timing
    wr(2'd0, 16'h5555); wr(2'd1, 16'h0003);
    for (int i = 0; i <= 5; i++) begin
      @(negedge clk); peek(2'd3, s); peek(2'd1, v);
      chk("R3 psc flag", s & 1, (i < 4) ? 1 : 0);
      chk("R3 psc value", v, (i < 4) ? 0 : 3);
    end
    // R3 reload update timing, R10 truncation
    wr(2'd2, 16'hF2A5);
    for (int i = 0; i <= 5; i++) begin
      @(negedge clk); peek(2'd3, s); peek(2'd2, v);
      chk("R3 rld flag", (s >> 1) & 1, (i < 4) ? 1 : 0);
      chk("R10 rld value", v, (i < 4) ? 12'hFFF : 12'h2A5);
    end
    // R10 prescaler keeps low 3 bits
    wr(2'd1, 16'hFFF9);
    repeat (6) @(posedge clk);
    rd(2'd1, v); chk("R10 psc trunc", v, 1);

    // R8 stopped: refresh does not start, no request
    do_reset();
    setup(0, 0);
    wr(2'd0, 16'hAAAA);
    measure(60, k); chk("R8 stopped quiet", k, 0);

    // R4 / R7 sweep over every code and several reload values
    for (int c = 0; c < 8; c++) begin
      for (int j = 0; j < 4; j++) begin
        do_reset();
        setup(c, rl_set[j]);
        wr(2'd0, 16'hCCCC);
        measure(3000, k); chk("R4 R7 first timeout", k, (rl_set[j] + 1) * ratio(c));
        measure(3000, k); chk("R4 period", k, (rl_set[j] + 1) * ratio(c));
      end
    end

    // R8 second start and unknown key do not stop or reload
    do_reset();
    setup(0, 1);
    wr(2'd0, 16'hCCCC);       // E0
    wr(2'd0, 16'hCCCC);       // E1
    measure(100, k); chk("R8 restart no reload", k, 7);
    wr(2'd0, 16'h1234);       // two edges after the request edge
    measure(100, k); chk("R8 unknown key keeps running", k, 6);
    // R6 start relocked: psc write ignored
    wr(2'd1, 16'h0002);
    rd(2'd3, v); chk("R6 relock by start", v, 0);

    // R5 refresh restarts period
    do_reset();
    setup(0, 2);
    wr(2'd0, 16'hCCCC);
    repeat (7) @(posedge clk);
    wr(2'd0, 16'hAAAA);
    measure(100, k); chk("R5 refresh delays", k, 12);

    // R9 refresh on the timeout edge suppresses the request
    do_reset();
    setup(0, 0);
    wr(2'd0, 16'hCCCC);
    repeat (3) @(posedge clk);
    wr(2'd0, 16'hAAAA);
    chk("R9 req suppressed", int'(wdt_reset_req), 0);
    measure(100, k); chk("R9 next timeout", k, 4);

    summary();
  end
endmodule